// File: doc/BRIEF.md
# Lines-Per-Frame Serial Encoder

This block measures how many horizontal lines arrive in each video field and reports an estimate of the lines in a full frame on a single serial wire. It counts horizontal sync leading edges between vertical sync leading edges. At each vertical sync leading edge it doubles the count, on the assumption that a frame has two fields, and holds the result. After the next vertical sync trailing edge it shifts that 11-bit value out, one bit per horizontal sync leading edge.

Both sync inputs are active low and are sampled in the system clock domain. A leading edge is a high-to-low transition and a trailing edge is a low-to-high transition. A downstream receiver can clock the serial wire with horizontal sync and reassemble the word. Dividing by two recovers the true line count of a progressive source.

Top module: `lpf_serial_encoder`

## Requirements
- R1: Every horizontal sync leading edge seen since the most recent vertical sync leading edge adds one to the field line count. At a vertical sync leading edge the count restarts from zero.
- R2: At each vertical sync leading edge the held frame value becomes twice the field line count, as unsigned binary. It saturates at 2047 when twice the count exceeds 2047.
- R3: After a vertical sync trailing edge, the held value is sent on the next 11 horizontal sync leading edges, most significant bit first. Each bit appears on `fmt_bit` two clock cycles after the input edge and stays there until the next horizontal sync leading edge.
- R4: `fmt_bit` is low in every other interval: from a vertical sync trailing edge up to the first bit slot, and from the horizontal sync leading edge after the 11th bit onwards.
- R5: After reset `fmt_bit` is low, the field line count is zero and no transmission is pending.
- R6: A vertical sync trailing edge that arrives before all 11 bits have been sent abandons the unfinished word. It starts a new 11-slot transmission of the currently held value.
- R7: `fmt_bit` changes only after a horizontal sync leading edge or a vertical sync trailing edge. A vertical sync leading edge alone leaves it unchanged.
- R8: Horizontal sync leading edges that occur while vertical sync is low belong to the new field and are included in its count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_n | input | 1 | Horizontal sync, active low, synchronous to clk |
| vsync_n | input | 1 | Vertical sync, active low, synchronous to clk |
| fmt_bit | output | 1 | Serial lines-per-frame word, MSB first |

## Verification
The encoder is driven with a directed sequence of fields whose line counts are small, exactly 1023 (giving 2046, the largest value that is not clipped) and above 1023 (which must saturate to 2047). These separate a correct doubling from an off-by-one count and from wrap-around. One field is cut short before its word finishes, to show that an unfinished transmission restarts rather than continues. Random fields then vary both the number of lines inside the vertical sync pulse and the number after it. Every slot and every idle line is compared with a reference word rebuilt from the bench's own count, which separates MSB-first ordering, correct slot counts and correct field attribution.

// File: rtl/lpf_pkg.sv
package lpf_pkg;
  // Single-cycle sync events derived from the sampled inputs.
  typedef struct packed {
    logic h_lead;   // hsync high -> low
    logic v_lead;   // vsync high -> low
    logic v_trail;  // vsync low -> high
  } sync_ev_t;
endpackage

// File: rtl/lpf_edge_detect.sv
module lpf_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_n,
  output logic fall,
  output logic rise
);
  logic samp_q;
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      samp_q <= sig_n;
      prev_q <= samp_q;
    end
  end

  assign fall = prev_q & ~samp_q;
  assign rise = ~prev_q & samp_q;
endmodule

// File: rtl/lpf_line_counter.sv
module lpf_line_counter #(
  parameter int WORD_W = 11,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lpf_pkg::sync_ev_t ev,
  output logic [CNT_W-1:0]  line_cnt,
  output logic [WORD_W-1:0] frame_val
);
  localparam logic [CNT_W:0]   WORD_MAX = {{(CNT_W+1-WORD_W){1'b0}}, {WORD_W{1'b1}}};
  localparam logic [CNT_W-1:0] CNT_TOP  = {CNT_W{1'b1}};

  // Doubling with clip to the largest word value.
  function automatic logic [WORD_W-1:0] dbl_sat(input logic [CNT_W-1:0] c);
    logic [CNT_W:0] d;
    d = {c, 1'b0};
    if (d > WORD_MAX) return {WORD_W{1'b1}};
    return d[WORD_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt  <= '0;
      frame_val <= '0;
    end else if (ev.v_lead) begin
      frame_val <= dbl_sat(line_cnt);
      line_cnt  <= ev.h_lead ? CNT_W'(1) : '0;
    end else if (ev.h_lead && line_cnt != CNT_TOP) begin
      line_cnt <= line_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/lpf_serializer.sv
module lpf_serializer #(
  parameter int WORD_W = 11,
  parameter int SLOT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lpf_pkg::sync_ev_t ev,
  input  logic [WORD_W-1:0] frame_val,
  output logic [SLOT_W-1:0] slots_left,
  output logic              ser_out
);
  localparam logic [SLOT_W-1:0] SLOTS = SLOT_W'(WORD_W);

  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      slots_left <= '0;
      ser_out    <= 1'b0;
    end else if (ev.v_trail) begin
      shreg      <= frame_val;
      slots_left <= SLOTS;
      ser_out    <= 1'b0;
    end else if (ev.h_lead) begin
      if (slots_left != '0) begin
        ser_out    <= shreg[WORD_W-1];
        shreg      <= {shreg[WORD_W-2:0], 1'b0};
        slots_left <= slots_left - SLOT_W'(1);
      end else begin
        ser_out <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lpf_serial_encoder.sv
module lpf_serial_encoder #(
  parameter int WORD_W = 11,
  parameter int CNT_W  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_n,
  input  logic vsync_n,
  output logic fmt_bit
);
  localparam int SLOT_W = $clog2(WORD_W + 1);

  logic              hs_lead;
  logic              hs_trail;
  logic              vs_lead;
  logic              vs_trail;
  lpf_pkg::sync_ev_t ev;
  logic [CNT_W-1:0]  line_cnt;
  logic [WORD_W-1:0] frame_val;
  logic [SLOT_W-1:0] slots_left;

  lpf_edge_detect u_hs_edge (
    .clk(clk), .rst_n(rst_n), .sig_n(hsync_n), .fall(hs_lead), .rise(hs_trail)
  );
  lpf_edge_detect u_vs_edge (
    .clk(clk), .rst_n(rst_n), .sig_n(vsync_n), .fall(vs_lead), .rise(vs_trail)
  );

  assign ev = '{h_lead: hs_lead, v_lead: vs_lead, v_trail: vs_trail};

  lpf_line_counter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .ev(ev), .line_cnt(line_cnt), .frame_val(frame_val)
  );

  lpf_serializer #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .ev(ev), .frame_val(frame_val),
    .slots_left(slots_left), .ser_out(fmt_bit)
  );
endmodule

// File: rtl/lpf_encoder_checker.sv
module lpf_encoder_checker #(
  parameter int WORD_W = 11,
  parameter int CNT_W  = 12,
  parameter int SLOT_W = $clog2(WORD_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hs_lead,
  input logic              vs_lead,
  input logic              vs_trail,
  input logic              fmt_bit,
  input logic [CNT_W-1:0]  line_cnt,
  input logic [SLOT_W-1:0] slots_left
);
  AST_QUIET_BETWEEN_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_lead || vs_trail) |=> $stable(fmt_bit)); // R7

  AST_LOW_AFTER_VTRAIL: assert property (@(posedge clk) disable iff (!rst_n)
    vs_trail |=> !fmt_bit); // R4

  AST_LOW_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_lead && !vs_trail && slots_left == '0) |=> !fmt_bit); // R4

  AST_SLOT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    vs_trail |=> slots_left == SLOT_W'(WORD_W)); // R6

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_lead && !vs_trail && slots_left != '0) |=>
      slots_left == $past(slots_left) - SLOT_W'(1)); // R3

  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    slots_left <= SLOT_W'(WORD_W)); // R3

  AST_FIELD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_lead && !hs_lead) |=> line_cnt == '0); // R1

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_lead && !vs_lead && line_cnt != {CNT_W{1'b1}}) |=>
      line_cnt == $past(line_cnt) + CNT_W'(1)); // R1
endmodule

bind lpf_serial_encoder lpf_encoder_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hs_lead(hs_lead), .vs_lead(vs_lead),
  .vs_trail(vs_trail), .fmt_bit(fmt_bit), .line_cnt(line_cnt),
  .slots_left(slots_left)
);

// File: tb/tb_lpf_serial_encoder.sv
module tb_lpf_serial_encoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_n = 1'b1;
  logic vsync_n = 1'b1;
  logic fmt_bit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state, kept from the requirements alone.
  int field_cnt = 0;   // lines since last vsync leading edge
  int held_val  = 0;   // frame value held at last vsync leading edge
  int send_val  = 0;   // word being transmitted
  int slot_idx  = 11;  // 11 means no slot pending
  bit exp_out   = 1'b0;
  string tag = "R3";

  lpf_serial_encoder dut (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n), .fmt_bit(fmt_bit)
  );

  always #10 clk = ~clk;

  function automatic int ref_frame(input int lines);
    int v;
    v = lines * 2;
    return (v > 2047) ? 2047 : v;
  endfunction

  function automatic bit ref_bit(input int word, input int idx);
    return bit'((word >> (10 - idx)) & 1);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: fmt_bit=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic hs_pulse();
    string r;
    @(negedge clk) hsync_n = 1'b0;
    field_cnt++;
    if (slot_idx < 11) begin
      exp_out = ref_bit(send_val, slot_idx);
      slot_idx++;
      r = tag;
    end else begin
      exp_out = 1'b0;
      r = "R4";
    end
    repeat (3) @(negedge clk);
    chk(r, fmt_bit, exp_out);
    hsync_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic vs_fall();
    @(negedge clk) vsync_n = 1'b0;
    held_val = ref_frame(field_cnt);
    field_cnt = 0;
    repeat (4) @(negedge clk);
    chk("R7", fmt_bit, exp_out);
  endtask

  task automatic vs_rise();
    @(negedge clk) vsync_n = 1'b1;
    send_val = held_val;
    slot_idx = 0;
    exp_out = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4", fmt_bit, 1'b0);
  endtask

  // R8: pulses inside the vsync low window count toward the new field.
  task automatic field(input int in_v, input int after);
    vs_fall();
    for (int i = 0; i < in_v; i++) hs_pulse();
    vs_rise();
    for (int i = 0; i < after; i++) hs_pulse();
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1981));
    repeat (3) @(negedge clk);
    chk("R5", fmt_bit, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5", fmt_bit, 1'b0);

    // R1 R2: small counts, lines before the first field
    for (int i = 0; i < 5; i++) hs_pulse();
    tag = "R1";
    field(3, 20);                 // sends 10
    tag = "R8";
    field(3, 20);                 // sends 46
    tag = "R2";
    field(2, 1021);               // sends 46; counts 1023
    field(3, 1100);               // sends 2046; counts 1103
    field(1, 4);                  // sends 2047 partially; counts 5
    tag = "R6";
    field(0, 15);                 // restart, sends 10
    tag = "R3";
    for (int f = 0; f < 8; f++) begin
      int a;
      int b;
      a = int'($urandom_range(5, 0));
      b = int'($urandom_range(400, 12));
      field(a, b);
    end
    field(2, 14);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule